// File: doc/BRIEF.md
# SIMD Shift-Left-by-Immediate and Insert Unit

This unit performs a lane-wise left shift by an immediate on a 128-bit SIMD register value. It supports two variants. In the plain variant, each lane of the source is shifted left and zeros enter at the bottom. In the insert variant, each lane keeps the low bits of the old destination that lie below the shift position. The shifted source bits fill the rest of the lane.

One 7-bit immediate sets both the lane width and the shift amount. The position of the highest set bit in the upper four immediate bits selects a lane width of 8, 16, 32 or 64 bits. The shift is the whole immediate minus that lane width.

A scalar mode works on a single 64-bit lane. A vector mode works on either the low half of the register or the whole register, as the half/full select chooses. Encodings that are not allowed set an unallocated flag and give a zero result.

Operands enter on a valid/ready stream and results leave on a second one, one cycle after acceptance. An operand is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stops new operands from entering. A result that is presented but not taken stays unchanged until `out_ready` rises.

Top module: `simd_shl_ins`

## Requirements
- R1: The lane width is 8, 16, 32 or 64 bits. It is chosen by the highest set bit among `in_imm[6:3]`: bit 3 gives 64, bit 2 gives 32, bit 1 gives 16 and bit 0 gives 8. The shift amount is `in_imm` minus the lane width, which gives 0 to width-1.
- R2: With `in_ins`=0, each allocated result lane equals the source lane shifted left by the shift amount, with zeros filled in at the bottom. The destination has no effect.
- R3: With `in_ins`=1, each result lane keeps destination bits [shift-1:0] and takes its upper width-shift bits from the low bits of the source lane. A shift of zero returns the source lane unchanged.
- R4: In vector mode (`in_scalar`=0) with `in_q`=0, only bits [63:0] are processed and result bits [127:64] are zero.
- R5: In vector mode with `in_q`=1, all lanes of the 128 bits are processed, including two 64-bit lanes when `in_imm[6]`=1. With `in_q`=0 and `in_imm[6]`=1 the encoding is unallocated.
- R6: In scalar mode (`in_scalar`=1), only a 64-bit lane is allowed. `in_imm[6]`=0 is unallocated. The result is lane 0 in bits [63:0], with bits [127:64] zero. `in_q` is ignored.
- R7: The unallocated flag `out_undef` is set when `in_imm[6:3]`=0 or when `in_opc` is not 5'h0A. Whenever `out_undef` is set, `out_res` is all zero.
- R8: A result appears on `out_valid` one cycle after its operand is accepted. While `out_valid`=1 and `out_ready`=0, `out_res` and `out_undef` hold and `in_ready` is low.
- R9: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be accepted |
| in_src | input | 128 | Source register value |
| in_dst | input | 128 | Old destination value (insert variant) |
| in_q | input | 1 | Vector full-width select (1 = 128 bits) |
| in_ins | input | 1 | 1 = insert, 0 = plain shift |
| in_scalar | input | 1 | 1 = scalar form, 0 = vector form |
| in_opc | input | 5 | Operation code; 5'h0A selects this unit |
| in_imm | input | 7 | Combined width/shift immediate |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 128 | Result value |
| out_undef | output | 1 | Encoding is unallocated |

## Verification
The assertions check four properties on every cycle:
- an upper half that must be zero after a half-width vector or scalar operand really is zero;
- an all-zero upper immediate field always raises the unallocated flag;
- a flagged result is always zero;
- a stalled result stays stable.

Only the bench's sweeps can show the lane arithmetic itself. They cover every immediate value under each mode, both variants and several data patterns, against a bit-by-bit model. Those sweeps include the insert mask at each shift amount, lane boundaries at every width, and shift zero.

// File: rtl/shl_pkg.sv
package shl_pkg;
  // Lane width class decoded from the immediate
  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;

  localparam int NUM_LW = 4;
  localparam int IMM_W  = 7;
  localparam int SHA_W  = 6;
  localparam logic [4:0] OPC_SHL = 5'h0A;

  function automatic logic [IMM_W-1:0] lane_bits(lane_w_e w);
    return IMM_W'(8) << w;
  endfunction
endpackage

// File: rtl/shl_imm_decode.sv
module shl_imm_decode
  import shl_pkg::*;
(
  input  logic [IMM_W-1:0] imm,
  input  logic [4:0]       opc,
  input  logic             q,
  input  logic             scalar,
  output lane_w_e          lw,
  output logic [SHA_W-1:0] sha,
  output logic             undef
);
  logic [3:0]       hi;
  logic [IMM_W-1:0] diff;

  assign hi = imm[IMM_W-1 -: 4];

  always_comb begin
    if (hi[3])      lw = LW_64;
    else if (hi[2]) lw = LW_32;
    else if (hi[1]) lw = LW_16;
    else            lw = LW_8;
  end

  assign diff = imm - lane_bits(lw);
  assign sha  = diff[SHA_W-1:0];

  always_comb begin
    undef = 1'b0;
    if (opc != OPC_SHL)         undef = 1'b1;
    if (hi == 4'd0)             undef = 1'b1;
    if (scalar && !hi[3])       undef = 1'b1;
    if (!scalar && hi[3] && !q) undef = 1'b1;
  end
endmodule

// File: rtl/shl_lane.sv
module shl_lane #(
  parameter int ES = 8,
  localparam int SW = $clog2(ES)
) (
  input  logic [ES-1:0] src,
  input  logic [ES-1:0] dst,
  input  logic [SW-1:0] sh,
  input  logic          ins,
  output logic [ES-1:0] res
);
  logic [ES-1:0] moved;
  logic [ES-1:0] keep;

  assign moved = src << sh;
  assign keep  = ~({ES{1'b1}} << sh);
  assign res   = ins ? (moved | (dst & keep)) : moved;
endmodule

// File: rtl/shl_slice.sv
module shl_slice #(
  parameter int VEC_W = 128,
  parameter int ES    = 8,
  localparam int SW    = $clog2(ES),
  localparam int LANES = VEC_W / ES
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic [SW-1:0]    sh,
  input  logic             ins,
  output logic [VEC_W-1:0] res
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    shl_lane #(.ES(ES)) u_lane (
      .src (src[l*ES +: ES]),
      .dst (dst[l*ES +: ES]),
      .sh  (sh),
      .ins (ins),
      .res (res[l*ES +: ES])
    );
  end
endmodule

// File: rtl/simd_shl_ins.sv
module simd_shl_ins
  import shl_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int HALF = VEC_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_src,
  input  logic [VEC_W-1:0] in_dst,
  input  logic             in_q,
  input  logic             in_ins,
  input  logic             in_scalar,
  input  logic [4:0]       in_opc,
  input  logic [6:0]       in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_res,
  output logic             out_undef
);
  lane_w_e          lw;
  logic [SHA_W-1:0] sha;
  logic             undef_d;
  logic [VEC_W-1:0] slice_res [NUM_LW];
  logic [VEC_W-1:0] res_d;
  logic             take;

  shl_imm_decode u_dec (
    .imm    (in_imm),
    .opc    (in_opc),
    .q      (in_q),
    .scalar (in_scalar),
    .lw     (lw),
    .sha    (sha),
    .undef  (undef_d)
  );

  for (genvar k = 0; k < NUM_LW; k++) begin : g_width
    localparam int ES = 8 << k;
    localparam int SW = $clog2(ES);
    shl_slice #(.VEC_W(VEC_W), .ES(ES)) u_slice (
      .src (in_src),
      .dst (in_dst),
      .sh  (sha[SW-1:0]),
      .ins (in_ins),
      .res (slice_res[k])
    );
  end

  always_comb begin
    res_d = slice_res[lw];
    if (in_scalar || !in_q) res_d[VEC_W-1:HALF] = '0;
    if (undef_d)            res_d = '0;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_undef <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_res   <= res_d;
        out_undef <= undef_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R4
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_scalar && !in_q) |=> (out_res[VEC_W-1:HALF] == '0));

  // R6
  scalar_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_scalar) |=> (out_res[VEC_W-1:HALF] == '0));

  // R7
  no_width_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_imm[6:3] == 4'd0) |=> (out_valid && out_undef));

  // R7
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_undef) |-> (out_res == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_undef)));
endmodule

// File: tb/simd_shl_ins_tb_top.sv
module simd_shl_ins_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_src = '0;
  logic [127:0] in_dst = '0;
  logic         in_q = 1'b0;
  logic         in_ins = 1'b0;
  logic         in_scalar = 1'b0;
  logic [4:0]   in_opc = 5'h0A;
  logic [6:0]   in_imm = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_res;
  logic         out_undef;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  simd_shl_ins dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_dst(in_dst), .in_q(in_q), .in_ins(in_ins),
    .in_scalar(in_scalar), .in_opc(in_opc), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_undef(out_undef)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string tag, logic [128:0] act, logic [128:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [128:0] model(logic [127:0] s, logic [127:0] d,
      logic q, logic ins, logic sc, logic [4:0] opc, logic [6:0] imm);
    int es;
    int sh;
    int lim;
    logic u;
    logic [127:0] r;
    es = imm[6] ? 64 : imm[5] ? 32 : imm[4] ? 16 : 8;
    sh = int'(imm) - es;
    u = (opc != 5'h0A) || (imm[6:3] == 0) || (sc && !imm[6]) || (!sc && imm[6] && !q);
    lim = (sc || !q) ? 64 : 128;
    r = '0;
    if (!u) begin
      for (int i = 0; i < lim; i++) begin
        int pos;
        pos = i % es;
        if (pos >= sh) r[i] = s[i - sh];
        else           r[i] = ins ? d[i] : 1'b0;
      end
    end
    return {u, r};
  endfunction

  function automatic string tag_of(logic [128:0] e, logic q, logic ins, logic sc, logic [6:0] imm);
    if (e[128]) begin
      if (imm[6:3] == 0) return "R7";
      if (sc) return "R6";
      return "R5";
    end
    if (sc) return "R6";
    if (!q) return "R4";
    if (imm[6]) return "R5";
    if (ins) return "R3";
    return "R2";
  endfunction

  task automatic xfer(logic [127:0] s, logic [127:0] d, logic q, logic ins,
      logic sc, logic [4:0] opc, logic [6:0] imm, string tag);
    logic [128:0] e;
    @(negedge clk);
    in_src = s; in_dst = d; in_q = q; in_ins = ins; in_scalar = sc;
    in_opc = opc; in_imm = imm; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(s, d, q, ins, sc, opc, imm);
    check(tag.len() == 0 ? tag_of(e, q, ins, sc, imm) : tag, {out_undef, out_res}, e);
    check("R8 valid", {128'd0, out_valid}, 129'd1);
  endtask

  logic [127:0] pat_s [3];
  logic [127:0] pat_d [3];

  initial begin
    pat_s[0] = 128'h0123456789abcdef_fedcba9876543210;
    pat_d[0] = 128'h5a5aa5a5_3c3cc3c3_0f0ff0f0_96966969;
    pat_s[1] = '1;
    pat_d[1] = '0;
    pat_s[2] = 128'h80000000_00000001_c0000000_00000003;
    pat_d[2] = '1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 out_valid", {128'd0, out_valid}, 129'd0);
    check("R9 in_ready", {128'd0, in_ready}, 129'd1);

    // R1: immh=0001, immb=011 -> 8-bit lanes, shift 3, plain
    xfer(pat_s[1], pat_d[1], 1'b1, 1'b0, 1'b0, 5'h0A, 7'b0001_011, "R1");
    check("R1 byte lanes", {1'b0, out_res}, {1'b0, {16{8'hF8}}});
    // R3: insert, shift 0 at 32-bit lanes copies source
    xfer(pat_s[0], pat_d[0], 1'b1, 1'b1, 1'b0, 5'h0A, 7'd32, "R3");
    check("R3 zero shift", {1'b0, out_res}, {1'b0, pat_s[0]});
    // R7: other opcode
    xfer(pat_s[0], pat_d[0], 1'b1, 1'b0, 1'b0, 5'h04, 7'd40, "R7");
    // R6: in_q ignored in scalar form
    xfer(pat_s[0], pat_d[0], 1'b1, 1'b0, 1'b1, 5'h0A, 7'd70, "R6");

    // Sweep: every immediate, three modes, both variants, three patterns
    for (int imm = 0; imm < 128; imm++)
      for (int m = 0; m < 3; m++)
        for (int ins = 0; ins < 2; ins++)
          for (int p = 0; p < 3; p++)
            xfer(pat_s[p], pat_d[p], m == 1, ins[0], m == 2, 5'h0A, 7'(imm), "");

    // R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_src = pat_s[1]; in_dst = '0; in_q = 1'b1; in_ins = 1'b0; in_scalar = 1'b0;
    in_opc = 5'h0A; in_imm = 7'd65; in_valid = 1'b1;
    @(negedge clk);
    in_src = pat_s[0]; in_imm = 7'd16;
    check("R8 stall ready", {128'd0, in_ready}, 129'd0);
    @(negedge clk);
    check("R8 hold", {out_undef, out_res}, model(pat_s[1], '0, 1'b1, 1'b0, 1'b0, 5'h0A, 7'd65));
    check("R8 hold valid", {128'd0, out_valid}, 129'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next", {out_undef, out_res}, model(pat_s[0], '0, 1'b1, 1'b0, 1'b0, 5'h0A, 7'd16));
    @(negedge clk);
    check("R8 drain", {128'd0, out_valid}, 129'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule